// File: doc/BRIEF.md
# Coherence Inbound Priority Event Decoder

This block sits in front of the per-line state machine of a private cache controller. It watches the heads of three inbound queues: responses from the directory or from peer caches, requests forwarded by the directory, and load/store requests from the core. In every cycle it picks one head by fixed priority and turns it into a single coherence event, together with the line address the event applies to. Directory data is split into "data, no acks pending" and "data, acks pending". The split uses the sum of the message's ack field and the line's outstanding-ack count, which comes in as a two's-complement number. Invalidation acks from peers are split into the final ack and earlier acks. A core request that misses in a full set becomes a replacement event for the supplied victim line.

The state machine answers an offered event with either accept or stall. On accept the decoder pops the chosen queue. On stall the head stays in its queue, and in the following cycle that queue is passed over, so the next queue in priority can be offered. The decoder keeps a small table of core lines with a request in flight. A later core request to one of those lines is held back until the controller reports that line done. Malformed heads are flagged and dropped.

Top module: `coh_evt_decoder`

## Requirements
- R1: Priority is fixed: a response head wins over a forwarded head, and a forwarded head wins over a core head. evSrc reports the chosen queue as 1 for responses, 2 for forwards, 3 for core, and 0 when no queue is chosen.
- R2: A directory response (rspFromDir=1) whose type is not data (data is rspType 0) is reported on errOut with no event. The response queue is popped in the same cycle, without waiting for accept.
- R3: For directory data, the ack field plus lkAcks (both two's complement) picks the event. A sum of zero gives event 7, and a positive sum gives event 8. A negative sum is an error, handled as in R2.
- R4: A data response (rspType 0) from a peer cache (rspFromDir=0) gives event 9.
- R5: An invalidation ack (rspType 1) from a peer gives event 11 when lkAcks equals 1 and event 10 for any other count. Any other peer response type is an error.
- R6: Forwarded types 0, 1, 2 and 3 give events 3, 4, 5 and 6 in that order. Forwarded types 4 to 7 are errors.
- R7: Core types 0 (load) and 1 (instruction fetch) both give event 0, and core type 2 (store) gives event 1. Core type 3 is an error. These rules apply only when R8 does not.
- R8: A core request with coreHit=0 and setFull=1 gives event 2 on victimAddr, whatever its type. Accepting this event does not pop the core queue and does not mark the line as in flight.
- R9: An accepted core load/store marks its line as in flight until doneValid names that line. While the line is in flight, core requests to it are not offered. When the in-flight table is full, no core request is offered.
- R10: A queue is popped only in a cycle where its head is offered and accepted, or flagged as an error, and at most one queue is popped per cycle. With neither accept nor stall, the same head is offered again in the next cycle.
- R11: A stall on an offered event keeps the head in its queue, and that queue is skipped for exactly the next cycle.
- R12: Core and done addresses are aligned to the line by clearing their low LINE_OFF bits. Core events carry the aligned address, and coreLineOut shows it.
- R13: After reset no event, error or pop is presented while the queues are empty, and no core line is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rspValid | input | 1 | Response queue head present |
| rspFromDir | input | 1 | Response sender is the directory |
| rspType | input | 2 | Response kind: 0 data, 1 invalidation ack |
| rspAcks | input | ACK_W | Ack field of directory data, two's complement |
| rspAddr | input | ADDR_W | Line address of the response |
| lkAcks | input | ACK_W | Outstanding-ack count of the response line, two's complement |
| fwdValid | input | 1 | Forward queue head present |
| fwdType | input | 3 | Forward kind: 0 share, 1 own, 2 invalidate, 3 put ack |
| fwdAddr | input | ADDR_W | Line address of the forward |
| coreValid | input | 1 | Core queue head present |
| coreType | input | 2 | Core kind: 0 load, 1 fetch, 2 store |
| coreAddr | input | ADDR_W | Byte address of the core request |
| coreHit | input | 1 | Core line is present in the cache |
| setFull | input | 1 | Core line's set has no free way |
| victimAddr | input | ADDR_W | Line chosen for eviction |
| doneValid | input | 1 | A core request has completed |
| doneAddr | input | ADDR_W | Address of the completed core request |
| smAccept | input | 1 | State machine takes the offered event |
| smStall | input | 1 | State machine refuses the offered event |
| evValid | output | 1 | Event offered |
| evType | output | 4 | Event code |
| evAddr | output | ADDR_W | Line address of the event |
| evSrc | output | 2 | Queue chosen this cycle |
| errOut | output | 1 | Chosen head is malformed and dropped |
| popRsp | output | 1 | Pop response queue |
| popFwd | output | 1 | Pop forward queue |
| popCore | output | 1 | Pop core queue |
| coreLineOut | output | ADDR_W | Aligned core line, used for the hit and set lookup |

## Verification
The bench builds the block with ADDR_W=16, LINE_OFF=4, ACK_W=4 and PEND=2. A 4-bit ack count lets the signed sum reach both ends of its range: 7 plus -8 is negative, and 7 plus 7 does not wrap. With only two in-flight slots, the full-table hold is reached after two accepted core requests. The 16-byte line makes the alignment of odd core and done addresses easy to observe.

// File: rtl/coh_dec_pkg.sv
package coh_dec_pkg;

  typedef enum logic [3:0] {
    EV_LOAD          = 4'd0,
    EV_STORE         = 4'd1,
    EV_REPL          = 4'd2,
    EV_FWD_SHARE     = 4'd3,
    EV_FWD_OWN       = 4'd4,
    EV_FWD_INV       = 4'd5,
    EV_PUT_ACK       = 4'd6,
    EV_DIR_DATA      = 4'd7,
    EV_DIR_DATA_ACKS = 4'd8,
    EV_PEER_DATA     = 4'd9,
    EV_INV_ACK       = 4'd10,
    EV_LAST_ACK      = 4'd11
  } cohEvent_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_RSP  = 2'd1,
    SRC_FWD  = 2'd2,
    SRC_CORE = 2'd3
  } cohSrc_e;

  localparam logic [1:0] RSP_DATA    = 2'd0;
  localparam logic [1:0] RSP_INV_ACK = 2'd1;

  localparam logic [2:0] FWD_SHARE   = 3'd0;
  localparam logic [2:0] FWD_OWN     = 3'd1;
  localparam logic [2:0] FWD_INV     = 3'd2;
  localparam logic [2:0] FWD_PUT_ACK = 3'd3;

  localparam logic [1:0] CORE_LOAD   = 2'd0;
  localparam logic [1:0] CORE_FETCH  = 2'd1;
  localparam logic [1:0] CORE_STORE  = 2'd2;

  // control -> datapath strobes
  typedef struct packed {
    cohSrc_e sel;
    logic    recordCore;
  } ctrlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic rspErr;
    logic fwdErr;
    logic coreErr;
    logic coreRepl;
    logic coreBlocked;
  } pathStatus_t;

endpackage

// File: rtl/coh_pend_track.sv
module coh_pend_track #(
  parameter int ADDR_W = 32,
  parameter int PEND   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lineIn,
  input  logic              record,
  input  logic              relValid,
  input  logic [ADDR_W-1:0] relLine,
  output logic              blocked,
  output logic              full
);

  logic [PEND-1:0]   slotValid;
  logic [ADDR_W-1:0] slotLine [PEND];
  logic [PEND-1:0]   matchVec;
  logic [PEND-1:0]   relVec;
  logic [PEND-1:0]   freeOh;

  always_comb begin
    logic found;
    found  = 1'b0;
    freeOh = '0;
    for (int i = 0; i < PEND; i++) begin
      if (!slotValid[i] && !found) begin
        freeOh[i] = 1'b1;
        found     = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < PEND; g++) begin : gSlot
    assign matchVec[g] = slotValid[g] && (slotLine[g] == lineIn);
    assign relVec[g]   = relValid && slotValid[g] && (slotLine[g] == relLine);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotValid[g] <= 1'b0;
        slotLine[g]  <= '0;
      end else if (relVec[g]) begin
        slotValid[g] <= 1'b0;
      end else if (record && freeOh[g]) begin
        slotValid[g] <= 1'b1;
        slotLine[g]  <= lineIn;
      end
    end
  end

  assign blocked = |matchVec;
  assign full    = &slotValid;

  // R9: a line is never recorded twice, nor into a full table
  p_no_dup_record_r9: assert property (@(posedge clk) disable iff (!rstN)
    record |-> (!blocked && !full));

  // R9: a released line is no longer blocking afterwards
  p_release_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    (relValid && !record && lineIn == relLine && blocked) |=>
      !(blocked && $stable(lineIn) && !$past(record)));

endmodule

// File: rtl/coh_dec_path.sv
module coh_dec_path
  import coh_dec_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFF = 6,
  parameter int ACK_W    = 6,
  parameter int PEND     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rspFromDir,
  input  logic [1:0]        rspType,
  input  logic [ACK_W-1:0]  rspAcks,
  input  logic [ADDR_W-1:0] rspAddr,
  input  logic [ACK_W-1:0]  lkAcks,
  input  logic [2:0]        fwdType,
  input  logic [ADDR_W-1:0] fwdAddr,
  input  logic [1:0]        coreType,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic              coreHit,
  input  logic              setFull,
  input  logic [ADDR_W-1:0] victimAddr,
  input  logic              doneValid,
  input  logic [ADDR_W-1:0] doneAddr,
  input  ctrlStrobe_t       strobe,
  output pathStatus_t       status,
  output cohEvent_e         evType,
  output logic [ADDR_W-1:0] evAddr,
  output logic [ADDR_W-1:0] coreLine
);

  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((64'd1 << LINE_OFF) - 64'd1);
  localparam logic [ACK_W-1:0]  ONE_ACK  = ACK_W'(1);

  logic [ADDR_W-1:0] doneLine;
  logic [ACK_W:0]    ackSum;
  cohEvent_e         rspEv, fwdEv, coreEv;
  logic              rspErr, fwdErr, coreErr, coreRepl;
  logic              pendBlocked, pendFull;

  assign coreLine = coreAddr & ~OFF_MASK;
  assign doneLine = doneAddr & ~OFF_MASK;

  // sign-extended sum, one bit wider so it cannot wrap
  assign ackSum = {rspAcks[ACK_W-1], rspAcks} + {lkAcks[ACK_W-1], lkAcks};

  always_comb begin
    rspEv  = EV_PEER_DATA;
    rspErr = 1'b0;
    if (rspFromDir) begin
      if (rspType != RSP_DATA || ackSum[ACK_W]) rspErr = 1'b1;
      else if (ackSum == '0)                    rspEv  = EV_DIR_DATA;
      else                                      rspEv  = EV_DIR_DATA_ACKS;
    end else begin
      unique case (rspType)
        RSP_DATA:    rspEv = EV_PEER_DATA;
        RSP_INV_ACK: rspEv = (lkAcks == ONE_ACK) ? EV_LAST_ACK : EV_INV_ACK;
        default:     rspErr = 1'b1;
      endcase
    end
  end

  always_comb begin
    fwdErr = 1'b0;
    fwdEv  = EV_FWD_SHARE;
    unique case (fwdType)
      FWD_SHARE:   fwdEv = EV_FWD_SHARE;
      FWD_OWN:     fwdEv = EV_FWD_OWN;
      FWD_INV:     fwdEv = EV_FWD_INV;
      FWD_PUT_ACK: fwdEv = EV_PUT_ACK;
      default:     fwdErr = 1'b1;
    endcase
  end

  assign coreRepl = !coreHit && setFull;

  always_comb begin
    coreErr = 1'b0;
    coreEv  = EV_LOAD;
    if (coreRepl) begin
      coreEv = EV_REPL;
    end else begin
      unique case (coreType)
        CORE_LOAD, CORE_FETCH: coreEv = EV_LOAD;
        CORE_STORE:            coreEv = EV_STORE;
        default:               coreErr = 1'b1;
      endcase
    end
  end

  always_comb begin
    evType = EV_LOAD;
    evAddr = '0;
    unique case (strobe.sel)
      SRC_RSP:  begin evType = rspEv;  evAddr = rspAddr; end
      SRC_FWD:  begin evType = fwdEv;  evAddr = fwdAddr; end
      SRC_CORE: begin evType = coreEv; evAddr = coreRepl ? victimAddr : coreLine; end
      default:  ;
    endcase
  end

  coh_pend_track #(.ADDR_W(ADDR_W), .PEND(PEND)) uTrack (
    .clk      (clk),
    .rstN     (rstN),
    .lineIn   (coreLine),
    .record   (strobe.recordCore),
    .relValid (doneValid),
    .relLine  (doneLine),
    .blocked  (pendBlocked),
    .full     (pendFull)
  );

  assign status.rspErr      = rspErr;
  assign status.fwdErr      = fwdErr;
  assign status.coreErr     = coreErr;
  assign status.coreRepl    = coreRepl;
  assign status.coreBlocked = pendBlocked || pendFull;

  // R5: the final-ack event only with exactly one ack outstanding
  p_last_ack_count_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sel == SRC_RSP && evType == EV_LAST_ACK) |-> (lkAcks == ONE_ACK && !rspFromDir));

  // R3: the no-acks data event only when the two counts cancel
  p_dir_zero_sum_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sel == SRC_RSP && evType == EV_DIR_DATA) |-> (rspAcks + lkAcks == '0));

  // R8: a replacement names the victim and only on a full-set miss
  p_repl_victim_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sel == SRC_CORE && evType == EV_REPL) |-> (evAddr == victimAddr && setFull && !coreHit));

  // R12: core events other than replacement carry a line-aligned address
  p_core_aligned_r12: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sel == SRC_CORE && evType != EV_REPL) |-> ((evAddr & OFF_MASK) == '0));

endmodule

// File: rtl/coh_dec_ctrl.sv
module coh_dec_ctrl
  import coh_dec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rspValid,
  input  logic        fwdValid,
  input  logic        coreValid,
  input  pathStatus_t status,
  input  logic        smAccept,
  input  logic        smStall,
  output ctrlStrobe_t strobe,
  output logic        evValid,
  output cohSrc_e     evSrc,
  output logic        errOut,
  output logic        popRsp,
  output logic        popFwd,
  output logic        popCore
);

  logic [2:0] skipQ, skipNext;
  logic       rspCand, fwdCand, coreCand;
  logic       selErr, take;
  cohSrc_e    sel;

  assign rspCand  = rspValid  && !skipQ[0];
  assign fwdCand  = fwdValid  && !skipQ[1];
  assign coreCand = coreValid && !skipQ[2] && !status.coreBlocked;

  always_comb begin
    if      (rspCand)  sel = SRC_RSP;
    else if (fwdCand)  sel = SRC_FWD;
    else if (coreCand) sel = SRC_CORE;
    else               sel = SRC_NONE;
  end

  always_comb begin
    unique case (sel)
      SRC_RSP:  selErr = status.rspErr;
      SRC_FWD:  selErr = status.fwdErr;
      SRC_CORE: selErr = status.coreErr;
      default:  selErr = 1'b0;
    endcase
  end

  assign errOut  = (sel != SRC_NONE) && selErr;
  assign evValid = (sel != SRC_NONE) && !selErr;
  assign evSrc   = sel;
  assign take    = errOut || (evValid && smAccept);

  assign popRsp  = take && sel == SRC_RSP;
  assign popFwd  = take && sel == SRC_FWD;
  assign popCore = take && sel == SRC_CORE && !status.coreRepl;

  assign strobe.sel        = sel;
  assign strobe.recordCore = evValid && smAccept && sel == SRC_CORE && !status.coreRepl;

  always_comb begin
    skipNext = '0;
    if (evValid && smStall) begin
      unique case (sel)
        SRC_RSP:  skipNext = 3'b001;
        SRC_FWD:  skipNext = 3'b010;
        SRC_CORE: skipNext = 3'b100;
        default:  skipNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) skipQ <= '0;
    else       skipQ <= skipNext;
  end

  // R10: never more than one queue popped in a cycle
  p_single_pop_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({popRsp, popFwd, popCore}));

  // R10: a pop needs an accept or a dropped malformed head
  p_pop_cause_r10: assert property (@(posedge clk) disable iff (!rstN)
    (popRsp || popFwd || popCore) |-> (smAccept || errOut));

  // R11: a stalled response head is not offered in the following cycle
  p_stall_yields_r11: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && smStall && evSrc == SRC_RSP) |=> (evSrc != SRC_RSP));

  // R1: a waiting response is chosen unless it was stalled a cycle ago
  p_rsp_first_r1: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !$past(evValid && smStall && evSrc == SRC_RSP)) |-> (evSrc == SRC_RSP));

endmodule

// File: rtl/coh_evt_decoder.sv
module coh_evt_decoder
  import coh_dec_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFF = 6,
  parameter int ACK_W    = 6,
  parameter int PEND     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rspValid,
  input  logic              rspFromDir,
  input  logic [1:0]        rspType,
  input  logic [ACK_W-1:0]  rspAcks,
  input  logic [ADDR_W-1:0] rspAddr,
  input  logic [ACK_W-1:0]  lkAcks,
  input  logic              fwdValid,
  input  logic [2:0]        fwdType,
  input  logic [ADDR_W-1:0] fwdAddr,
  input  logic              coreValid,
  input  logic [1:0]        coreType,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic              coreHit,
  input  logic              setFull,
  input  logic [ADDR_W-1:0] victimAddr,
  input  logic              doneValid,
  input  logic [ADDR_W-1:0] doneAddr,
  input  logic              smAccept,
  input  logic              smStall,
  output logic              evValid,
  output logic [3:0]        evType,
  output logic [ADDR_W-1:0] evAddr,
  output logic [1:0]        evSrc,
  output logic              errOut,
  output logic              popRsp,
  output logic              popFwd,
  output logic              popCore,
  output logic [ADDR_W-1:0] coreLineOut
);

  ctrlStrobe_t strobe;
  pathStatus_t status;
  cohEvent_e   evTypeE;
  cohSrc_e     evSrcE;

  coh_dec_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .rspValid  (rspValid),
    .fwdValid  (fwdValid),
    .coreValid (coreValid),
    .status    (status),
    .smAccept  (smAccept),
    .smStall   (smStall),
    .strobe    (strobe),
    .evValid   (evValid),
    .evSrc     (evSrcE),
    .errOut    (errOut),
    .popRsp    (popRsp),
    .popFwd    (popFwd),
    .popCore   (popCore)
  );

  coh_dec_path #(.ADDR_W(ADDR_W), .LINE_OFF(LINE_OFF), .ACK_W(ACK_W), .PEND(PEND)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .rspFromDir (rspFromDir),
    .rspType    (rspType),
    .rspAcks    (rspAcks),
    .rspAddr    (rspAddr),
    .lkAcks     (lkAcks),
    .fwdType    (fwdType),
    .fwdAddr    (fwdAddr),
    .coreType   (coreType),
    .coreAddr   (coreAddr),
    .coreHit    (coreHit),
    .setFull    (setFull),
    .victimAddr (victimAddr),
    .doneValid  (doneValid),
    .doneAddr   (doneAddr),
    .strobe     (strobe),
    .status     (status),
    .evType     (evTypeE),
    .evAddr     (evAddr),
    .coreLine   (coreLineOut)
  );

  assign evType = evTypeE;
  assign evSrc  = evSrcE;

endmodule

// File: tb/sim_coh_evt_decoder.sv
`timescale 1ns/1ps
module sim_coh_evt_decoder;

  localparam int ADDR_W = 16;
  localparam int LINE_OFF = 4;
  localparam int ACK_W = 4;
  localparam int PEND = 2;
  localparam logic [15:0] A_RSP = 16'h1230;
  localparam logic [15:0] A_FWD = 16'h4560;
  localparam logic [15:0] A_CORE = 16'h789A;
  localparam logic [15:0] A_CLINE = 16'h7890;
  localparam logic [15:0] A_VIC = 16'hABC0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rspValid = 0, rspFromDir = 0, fwdValid = 0, coreValid = 0;
  logic [1:0] rspType = 0, coreType = 0;
  logic [3:0] rspAcks = 0, lkAcks = 0;
  logic [2:0] fwdType = 0;
  logic [15:0] rspAddr = A_RSP, fwdAddr = A_FWD, coreAddr = A_CORE, victimAddr = A_VIC;
  logic coreHit = 1, setFull = 0, doneValid = 0, smAccept = 0, smStall = 0;
  logic [15:0] doneAddr = 0;
  logic evValid, errOut, popRsp, popFwd, popCore;
  logic [3:0] evType;
  logic [1:0] evSrc;
  logic [15:0] evAddr, coreLineOut;

  int nChecks = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  coh_evt_decoder #(.ADDR_W(ADDR_W), .LINE_OFF(LINE_OFF), .ACK_W(ACK_W), .PEND(PEND)) u0 (
    .clk(clk), .rstN(rstN), .rspValid(rspValid), .rspFromDir(rspFromDir), .rspType(rspType),
    .rspAcks(rspAcks), .rspAddr(rspAddr), .lkAcks(lkAcks), .fwdValid(fwdValid),
    .fwdType(fwdType), .fwdAddr(fwdAddr), .coreValid(coreValid), .coreType(coreType),
    .coreAddr(coreAddr), .coreHit(coreHit), .setFull(setFull), .victimAddr(victimAddr),
    .doneValid(doneValid), .doneAddr(doneAddr), .smAccept(smAccept), .smStall(smStall),
    .evValid(evValid), .evType(evType), .evAddr(evAddr), .evSrc(evSrc), .errOut(errOut),
    .popRsp(popRsp), .popFwd(popFwd), .popCore(popCore), .coreLineOut(coreLineOut)
  );

  typedef struct packed {
    logic [3:0] rq;
    logic rv; logic rd; logic [1:0] rt; logic [3:0] ra; logic [3:0] lk;
    logic fv; logic [2:0] ft;
    logic cv; logic [1:0] ct; logic ch; logic sf;
    logic eV; logic eE; logic [1:0] eS; logic [3:0] eT;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    // rq rv rd rt  ra    lk    fv ft  cv ct ch sf | eV eE eS eT
    '{4'd3, 1,1,2'd0,4'd2,4'hE, 0,3'd0, 0,2'd0,1,0, 1,0,2'd1,4'd7},   // R3 sum zero
    '{4'd3, 1,1,2'd0,4'd3,4'hF, 0,3'd0, 0,2'd0,1,0, 1,0,2'd1,4'd8},   // R3 sum positive
    '{4'd3, 1,1,2'd0,4'd1,4'hD, 0,3'd0, 0,2'd0,1,0, 0,1,2'd1,4'd0},   // R3 sum negative
    '{4'd3, 1,1,2'd0,4'd7,4'h8, 0,3'd0, 0,2'd0,1,0, 0,1,2'd1,4'd0},   // R3 7 + -8
    '{4'd3, 1,1,2'd0,4'd7,4'd7, 0,3'd0, 0,2'd0,1,0, 1,0,2'd1,4'd8},   // R3 7 + 7 no wrap
    '{4'd2, 1,1,2'd1,4'd0,4'd0, 0,3'd0, 0,2'd0,1,0, 0,1,2'd1,4'd0},   // R2 dir ack type
    '{4'd2, 1,1,2'd2,4'd0,4'd0, 1,3'd0, 0,2'd0,1,0, 0,1,2'd1,4'd0},   // R2 with forward waiting
    '{4'd4, 1,0,2'd0,4'd5,4'd3, 0,3'd0, 0,2'd0,1,0, 1,0,2'd1,4'd9},   // R4 peer data
    '{4'd5, 1,0,2'd1,4'd0,4'd1, 0,3'd0, 0,2'd0,1,0, 1,0,2'd1,4'd11},  // R5 last ack
    '{4'd5, 1,0,2'd1,4'd0,4'd2, 0,3'd0, 0,2'd0,1,0, 1,0,2'd1,4'd10},  // R5 two left
    '{4'd5, 1,0,2'd1,4'd0,4'hF, 0,3'd0, 0,2'd0,1,0, 1,0,2'd1,4'd10},  // R5 negative count
    '{4'd5, 1,0,2'd3,4'd0,4'd1, 0,3'd0, 0,2'd0,1,0, 0,1,2'd1,4'd0},   // R5 bad peer type
    '{4'd6, 0,0,2'd0,4'd0,4'd0, 1,3'd0, 0,2'd0,1,0, 1,0,2'd2,4'd3},   // R6 share
    '{4'd6, 0,0,2'd0,4'd0,4'd0, 1,3'd1, 0,2'd0,1,0, 1,0,2'd2,4'd4},   // R6 own
    '{4'd6, 0,0,2'd0,4'd0,4'd0, 1,3'd2, 0,2'd0,1,0, 1,0,2'd2,4'd5},   // R6 invalidate
    '{4'd6, 0,0,2'd0,4'd0,4'd0, 1,3'd3, 0,2'd0,1,0, 1,0,2'd2,4'd6},   // R6 put ack
    '{4'd6, 0,0,2'd0,4'd0,4'd0, 1,3'd5, 1,2'd0,1,0, 0,1,2'd2,4'd0},   // R6 bad type
    '{4'd7, 0,0,2'd0,4'd0,4'd0, 0,3'd0, 1,2'd0,1,0, 1,0,2'd3,4'd0},   // R7 load
    '{4'd7, 0,0,2'd0,4'd0,4'd0, 0,3'd0, 1,2'd1,1,0, 1,0,2'd3,4'd0},   // R7 fetch
    '{4'd7, 0,0,2'd0,4'd0,4'd0, 0,3'd0, 1,2'd2,1,0, 1,0,2'd3,4'd1},   // R7 store
    '{4'd7, 0,0,2'd0,4'd0,4'd0, 0,3'd0, 1,2'd3,1,0, 0,1,2'd3,4'd0},   // R7 bad type
    '{4'd7, 0,0,2'd0,4'd0,4'd0, 0,3'd0, 1,2'd2,0,0, 1,0,2'd3,4'd1},   // R7 miss, room left
    '{4'd8, 0,0,2'd0,4'd0,4'd0, 0,3'd0, 1,2'd0,0,1, 1,0,2'd3,4'd2},   // R8 replacement
    '{4'd8, 0,0,2'd0,4'd0,4'd0, 0,3'd0, 1,2'd3,0,1, 1,0,2'd3,4'd2},   // R8 over bad type
    '{4'd1, 1,0,2'd0,4'd0,4'd0, 1,3'd1, 1,2'd2,1,0, 1,0,2'd1,4'd9},   // R1 all three
    '{4'd1, 0,0,2'd0,4'd0,4'd0, 1,3'd2, 1,2'd2,1,0, 1,0,2'd2,4'd5},   // R1 forward over core
    '{4'd13,0,0,2'd0,4'd0,4'd0, 0,3'd0, 0,2'd0,1,0, 0,0,2'd0,4'd0}    // R13 idle
  };

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    rspValid = 0; rspFromDir = 0; rspType = 0; rspAcks = 0; lkAcks = 0;
    fwdValid = 0; fwdType = 0; coreValid = 0; coreType = 0; coreAddr = A_CORE;
    coreHit = 1; setFull = 0; doneValid = 0; doneAddr = 0; smAccept = 0; smStall = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog: actual expired expected done");
    summary();
  end

  initial begin
    idle();
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    // R13 reset state
    check("R13", "idle outputs", {evValid, errOut, popRsp, popFwd, popCore}, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      rspValid = VECS[i].rv; rspFromDir = VECS[i].rd; rspType = VECS[i].rt;
      rspAcks = VECS[i].ra; lkAcks = VECS[i].lk; fwdValid = VECS[i].fv; fwdType = VECS[i].ft;
      coreValid = VECS[i].cv; coreType = VECS[i].ct; coreHit = VECS[i].ch; setFull = VECS[i].sf;
      smAccept = 0; smStall = 0;
      #1;
      check($sformatf("R%0d", VECS[i].rq), $sformatf("vec %0d valid/err/src", i),
            {evValid, errOut, evSrc}, {VECS[i].eV, VECS[i].eE, VECS[i].eS});
      if (VECS[i].eV) begin
        logic [15:0] ea;
        ea = (VECS[i].eS == 2'd1) ? A_RSP : (VECS[i].eS == 2'd2) ? A_FWD :
             (VECS[i].eT == 4'd2) ? A_VIC : A_CLINE;
        check($sformatf("R%0d", VECS[i].rq), $sformatf("vec %0d type/addr", i),
              {evType, evAddr}, {VECS[i].eT, ea});
      end
      // R10 no accept, no pop unless error
      check("R10", $sformatf("vec %0d pops", i), {popRsp, popFwd, popCore},
            {VECS[i].eE && VECS[i].eS == 2'd1, VECS[i].eE && VECS[i].eS == 2'd2,
             VECS[i].eE && VECS[i].eS == 2'd3});
    end

    // R12 alignment seen on coreLineOut
    @(negedge clk); idle(); coreAddr = 16'h123F; #1;
    check("R12", "coreLineOut", coreLineOut, 16'h1230);

    // R10 held offer, then accepted pop
    @(negedge clk); idle(); rspValid = 1; rspType = 2'd0; #1;
    check("R10", "no pop without accept", popRsp, 0);
    @(negedge clk); smAccept = 1; #1;
    check("R10", "held then popped", {evSrc, popRsp}, {2'd1, 1'b1});

    // R2 malformed directory response dropped without accept
    @(negedge clk); idle(); rspValid = 1; rspFromDir = 1; rspType = 2'd1; #1;
    check("R2", "error pop", {errOut, evValid, popRsp}, 3'b101);

    // R11 stall yields to next queue for one cycle
    @(negedge clk); idle(); rspValid = 1; fwdValid = 1; fwdType = 3'd0; smStall = 1; #1;
    check("R11", "stalled head offered", evSrc, 2'd1);
    @(negedge clk); smStall = 0; #1;
    check("R11", "next queue offered", {evSrc, evType, popRsp}, {2'd2, 4'd3, 1'b0});
    @(negedge clk); #1;
    check("R11", "skip lasts one cycle", evSrc, 2'd1);

    // R8 accepted replacement: no pop, no in-flight mark
    @(negedge clk); idle(); coreValid = 1; coreType = 2'd0; coreHit = 0; setFull = 1; smAccept = 1; #1;
    check("R8", "repl not popped", {evType, evAddr, popCore}, {4'd2, A_VIC, 1'b0});
    @(negedge clk); coreHit = 1; setFull = 0; smAccept = 0; #1;
    check("R8", "line not marked", {evValid, evType, evAddr}, {1'b1, 4'd0, A_CLINE});

    // R9 in-flight lines
    @(negedge clk); idle(); coreValid = 1; coreAddr = 16'h1005; smAccept = 1; #1;
    check("R9", "first line accepted", {evValid, popCore}, 2'b11);
    @(negedge clk); coreAddr = 16'h100C; smAccept = 0; #1;
    check("R9", "same line held", {evValid, evSrc}, {1'b0, 2'd0});
    @(negedge clk); coreAddr = 16'h2000; smAccept = 1; #1;
    check("R9", "other line accepted", {evValid, popCore}, 2'b11);
    @(negedge clk); coreAddr = 16'h3000; smAccept = 0; #1;
    check("R9", "table full holds", evValid, 0);
    @(negedge clk); doneValid = 1; doneAddr = 16'h1003; #1;
    check("R9", "release takes a cycle", evValid, 0);
    @(negedge clk); doneValid = 0; #1;
    check("R9", "offered after release", {evValid, evAddr}, {1'b1, 16'h3000});
    @(negedge clk); coreAddr = 16'h1008; #1;
    check("R12", "released line offered aligned", {evValid, evAddr}, {1'b1, 16'h1000});

    @(negedge clk); idle();
    @(negedge clk);
    summary();
  end

endmodule